// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a sixteen-pin general purpose I/O port controlled through a small memory-mapped register bank on a 16-bit register bus. Software sets, per pin, whether the pin drives out or samples in. Output pins drive the pin data register. Input pins that have their input buffer enabled copy the synchronised external level into that same register. Two interrupt mask registers, as well as polarity, edge-select and both-edge configuration words, are stored here and presented on ports for a separate interrupt unit.

The pin data register and both mask registers each sit in a group of four addresses: a plain write address, a write-one-to-clear alias, a write-one-to-set alias and a write-one-to-toggle alias. These aliases let software change single bits without a read-modify-write. A read from any of the four addresses returns the underlying register. Only halfword, aligned accesses inside the map are accepted. Any other access is refused, changes nothing, and raises a sticky error flag that software clears through a status register.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero. `pin_oe`, `pin_out`, the mask and configuration ports and `bus_err` are all zero.
- R2: Register index = byte address / 4. The plain registers are at index 0 (pin data), 4 (mask A), 8 (mask B), 12 (direction), 13 (polarity), 14 (edge select), 15 (both edges) and 16 (input enable). A plain write stores `bus_wdata`, and a read of the same address returns it.
- R3: Writing to group offset +1 (indices 1, 5, 9) clears each bit of that group's register where `bus_wdata` is 1.
- R4: Writing to group offset +2 (indices 2, 6, 10) ORs `bus_wdata` into that group's register.
- R5: Writing to group offset +3 (indices 3, 7, 11) XORs `bus_wdata` into that group's register.
- R6: A read of any of the four addresses of a group returns the current value of that group's register.
- R7: An access is legal only when `bus_size` is 1 (halfword; 0 = byte, 2 = word), the address has bits [1:0] equal to zero, and the index is at most 17. An illegal access changes no register, reads back 0, and sets `bus_err` on the next clock.
- R8: `bus_err` stays set until software writes a value with bit 0 = 1 to the status register at index 17 (byte address 0x44). Writing 0 there leaves it set. A read of the status register returns `bus_err` in bit 0.
- R9: `pin_oe` equals the direction register. `pin_out[i]` equals pin data bit i when direction bit i is 1, and is 0 otherwise.
- R10: When a pin has direction 0 and input enable 1, its pin data bit takes the level of `pin_in` three clocks after that level changes. Two synchroniser stages come first, then the register. Bus writes do not alter such a bit.
- R11: When a pin has direction 1 or input enable 0, `pin_in` has no effect on its pin data bit.
- R12: `mask_a`, `mask_b`, `cfg_polar`, `cfg_edge` and `cfg_both` always show the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (same cycle as `bus_rd`) |
| bus_err | output | 1 | Sticky illegal-access flag |
| pin_in | input | 16 | External pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| mask_a | output | 16 | Interrupt mask A |
| mask_b | output | 16 | Interrupt mask B |
| cfg_polar | output | 16 | Interrupt polarity word |
| cfg_edge | output | 16 | Interrupt edge-select word |
| cfg_both | output | 16 | Interrupt both-edge word |

## Verification
On every cycle, the assertions check three things. An illegal access raises the error flag and leaves the configuration ports unchanged. The error flag holds until it is cleared. Each pin data bit either follows the synchroniser output or holds, as its direction and input enable require. The alias arithmetic, the read-back through every alias address and the exact three-clock input latency can only be shown by the bench scenarios. Those scenarios sweep every group and alias with several bit patterns, and they probe the sampled bit one clock before and at the cycle it must change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int REG_W   = 16;
    localparam int SYNC_N  = 2;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam int STAT_ERR_BIT = 0;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef enum logic [3:0] {
        GRP_DATA,
        GRP_MASKA,
        GRP_MASKB,
        GRP_DIR,
        GRP_POLAR,
        GRP_EDGE,
        GRP_BOTH,
        GRP_INEN,
        GRP_STAT,
        GRP_NONE
    } reg_grp_e;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] mask_a;
        logic [REG_W-1:0] mask_b;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] polar;
        logic [REG_W-1:0] edge_sel;
        logic [REG_W-1:0] both;
        logic [REG_W-1:0] inen;
        logic             err;
    } bank_state_t;

    function automatic logic [REG_W-1:0] apply_alias(
        input alias_op_e        op,
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] val
    );
        logic [REG_W-1:0] res;
        case (op)
            OP_CLEAR:  res = cur & ~val;
            OP_SET:    res = cur | val;
            OP_TOGGLE: res = cur ^ val;
            default:   res = val;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            always_comb stage_d = async_in;
        end else begin : g_next
            always_comb stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output reg_grp_e          grp,
    output alias_op_e         op
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             size_ok;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign size_ok = (size == SZ_HALF);

    always_comb begin
        op  = OP_WRITE;
        grp = GRP_NONE;
        case (int'(idx))
            0, 1, 2, 3: begin
                grp = GRP_DATA;
                op  = alias_op_e'(idx[1:0]);
            end
            4, 5, 6, 7: begin
                grp = GRP_MASKA;
                op  = alias_op_e'(idx[1:0]);
            end
            8, 9, 10, 11: begin
                grp = GRP_MASKB;
                op  = alias_op_e'(idx[1:0]);
            end
            12:      grp = GRP_DIR;
            13:      grp = GRP_POLAR;
            14:      grp = GRP_EDGE;
            15:      grp = GRP_BOTH;
            16:      grp = GRP_INEN;
            17:      grp = GRP_STAT;
            default: grp = GRP_NONE;
        endcase
    end

    assign hit = aligned && size_ok && (grp != GRP_NONE);

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_bank_pkg::*;
(
    input  logic             rd_en,
    input  logic             hit,
    input  reg_grp_e         grp,
    input  bank_state_t      st,
    output logic [REG_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en && hit) begin
            case (grp)
                GRP_DATA:  rdata = st.data;
                GRP_MASKA: rdata = st.mask_a;
                GRP_MASKB: rdata = st.mask_b;
                GRP_DIR:   rdata = st.dir;
                GRP_POLAR: rdata = st.polar;
                GRP_EDGE:  rdata = st.edge_sel;
                GRP_BOTH:  rdata = st.both;
                GRP_INEN:  rdata = st.inen;
                GRP_STAT:  rdata[STAT_ERR_BIT] = st.err;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [REG_W-1:0]  pin_in,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_oe,
    output logic [REG_W-1:0]  mask_a,
    output logic [REG_W-1:0]  mask_b,
    output logic [REG_W-1:0]  cfg_polar,
    output logic [REG_W-1:0]  cfg_edge,
    output logic [REG_W-1:0]  cfg_both
);

    bank_state_t      s_d, s_q;
    logic             dec_hit;
    reg_grp_e         dec_grp;
    alias_op_e        dec_op;
    logic [REG_W-1:0] pin_sync;
    logic [REG_W-1:0] samp_en;
    logic             err_clr;

    gpio_sync #(
        .WIDTH  (REG_W),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .hit  (dec_hit),
        .grp  (dec_grp),
        .op   (dec_op)
    );

    gpio_readback u_rb (
        .rd_en (bus_rd),
        .hit   (dec_hit),
        .grp   (dec_grp),
        .st    (s_q),
        .rdata (bus_rdata)
    );

    assign samp_en = ~s_q.dir & s_q.inen;
    assign err_clr = bus_wr && dec_hit && (dec_grp == GRP_STAT)
                     && bus_wdata[STAT_ERR_BIT];

    always_comb begin
        s_d = s_q;
        if (bus_wr && dec_hit) begin
            case (dec_grp)
                GRP_DATA:  s_d.data     = apply_alias(dec_op, s_q.data, bus_wdata);
                GRP_MASKA: s_d.mask_a   = apply_alias(dec_op, s_q.mask_a, bus_wdata);
                GRP_MASKB: s_d.mask_b   = apply_alias(dec_op, s_q.mask_b, bus_wdata);
                GRP_DIR:   s_d.dir      = bus_wdata;
                GRP_POLAR: s_d.polar    = bus_wdata;
                GRP_EDGE:  s_d.edge_sel = bus_wdata;
                GRP_BOTH:  s_d.both     = bus_wdata;
                GRP_INEN:  s_d.inen     = bus_wdata;
                default:   ;
            endcase
        end
        if (err_clr) begin
            s_d.err = 1'b0;
        end
        s_d.data = (s_d.data & ~samp_en) | (pin_sync & samp_en);
        if ((bus_wr || bus_rd) && !dec_hit) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_out   = s_q.data & s_q.dir;
    assign pin_oe    = s_q.dir;
    assign mask_a    = s_q.mask_a;
    assign mask_b    = s_q.mask_b;
    assign cfg_polar = s_q.polar;
    assign cfg_edge  = s_q.edge_sel;
    assign cfg_both  = s_q.both;
    assign bus_err   = s_q.err;

    AST_BAD_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !dec_hit) |=> bus_err); // R7

    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dec_hit) |=> ($stable(pin_oe) && $stable(mask_a) && $stable(mask_b)
                                  && $stable(cfg_polar) && $stable(cfg_edge) && $stable(cfg_both))); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_clr) |=> bus_err); // R8

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_hit && dec_grp == GRP_DIR) |=> (pin_oe == $past(bus_wdata))); // R9

    AST_SAMPLED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((s_q.data ^ $past(pin_sync)) & $past(samp_en)) == '0)); // R10

    AST_UNSAMPLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (((s_q.data ^ $past(s_q.data)) & ~$past(samp_en)) == '0)); // R11

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, mask_a, mask_b, cfg_polar, cfg_edge, cfg_both;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .mask_a(mask_a), .mask_b(mask_b), .cfg_polar(cfg_polar), .cfg_edge(cfg_edge),
        .cfg_both(cfg_both)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v, input logic [1:0] sz = 2'd1);
        bus_addr = a; bus_size = sz; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'd1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v, input logic [1:0] sz = 2'd1);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 2'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, m, p0, pc, ps, pt, exp_d;
        logic [7:0]  base;
        logic [15:0] cfg [8];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 18; i++) begin
            rd(8'(i * 4), v);
            chk("R1 reg", v, 16'h0000);
        end
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);
        chk("R1 bus_err", {15'b0, bus_err}, 16'h0000);
        chk("R1 mask_a", mask_a, 16'h0000);

        // R2: plain registers write/read, then config ports (R12)
        for (int k = 0; k < 8; k++) begin
            int idx;
            idx = (k < 3) ? k * 4 : 9 + k;
            cfg[k] = 16'hA5C3 ^ 16'((k + 1) * 16'h1357);
            wr(8'(idx * 4), cfg[k]);
            rd(8'(idx * 4), v);
            chk("R2 plain readback", v, cfg[k]);
        end
        chk("R12 mask_a", mask_a, cfg[1]);
        chk("R12 mask_b", mask_b, cfg[2]);
        chk("R9 pin_oe", pin_oe, cfg[3]);
        chk("R12 cfg_polar", cfg_polar, cfg[4]);
        chk("R12 cfg_edge", cfg_edge, cfg[5]);
        chk("R12 cfg_both", cfg_both, cfg[6]);
        wr(8'h40, 16'h0000);
        wr(8'h30, 16'h0000);

        // R3 R4 R5 R6: alias sweep over all three groups
        for (int g = 0; g < 3; g++) begin
            base = 8'(g * 16);
            for (int p = 0; p < 4; p++) begin
                p0 = 16'h3C5A + 16'(p * 16'h0F1F);
                pc = 16'h00FF << (p * 2);
                ps = 16'h8001 | 16'(p * 16'h0110);
                pt = 16'hFFFF >> p;
                wr(base, p0); m = p0;
                wr(base + 8'd4, pc); m = m & ~pc;
                rd(base, v); chk("R3 clear alias", v, m);
                wr(base + 8'd8, ps); m = m | ps;
                rd(base, v); chk("R4 set alias", v, m);
                wr(base + 8'd12, pt); m = m ^ pt;
                rd(base, v); chk("R5 toggle alias", v, m);
                for (int a = 1; a < 4; a++) begin
                    rd(base + 8'(a * 4), v);
                    chk("R6 alias read", v, m);
                end
            end
        end
        chk("R12 mask_a after aliases", mask_a, u_exp_a());

        // R7: illegal accesses
        wr(8'h30, 16'h1234);
        wr(8'h30, 16'hFFFF, 2'd0);
        chk("R7 byte write err", {15'b0, bus_err}, 16'h0001);
        rd(8'h30, v); chk("R7 byte write no effect", v, 16'h1234);
        wr(8'h44, 16'h0001);
        wr(8'h30, 16'hFFFF, 2'd2);
        chk("R7 word write err", {15'b0, bus_err}, 16'h0001);
        chk("R7 word write no effect", pin_oe, 16'h1234);
        wr(8'h44, 16'h0001);
        wr(8'h32, 16'hFFFF);
        chk("R7 unaligned err", {15'b0, bus_err}, 16'h0001);
        chk("R7 unaligned no effect", pin_oe, 16'h1234);
        wr(8'h44, 16'h0001);
        wr(8'h48, 16'hFFFF);
        chk("R7 out of map err", {15'b0, bus_err}, 16'h0001);
        wr(8'h44, 16'h0001);
        chk("R8 cleared", {15'b0, bus_err}, 16'h0000);
        rd(8'h30, v, 2'd2);
        chk("R7 bad read data", v, 16'h0000);
        chk("R7 bad read err", {15'b0, bus_err}, 16'h0001);

        // R8: sticky flag
        wr(8'h34, 16'h0001);
        chk("R8 sticky over valid write", {15'b0, bus_err}, 16'h0001);
        wr(8'h44, 16'h0000);
        chk("R8 zero write keeps", {15'b0, bus_err}, 16'h0001);
        rd(8'h44, v); chk("R8 status read set", v, 16'h0001);
        wr(8'h44, 16'h0001);
        rd(8'h44, v); chk("R8 status read clear", v, 16'h0000);

        // R9: output drive
        wr(8'h30, 16'hFF00);
        wr(8'h00, 16'h5A5A);
        chk("R9 pin_out", pin_out, 16'h5A00);
        wr(8'h0C, 16'h0F0F);
        chk("R9 pin_out after toggle", pin_out, 16'h5500);
        wr(8'h30, 16'h00FF);
        chk("R9 pin_out dir swap", pin_out, 16'h0055);

        // R10 R11: input sampling (sampled pins = ~dir & inen = 0x0F00)
        wr(8'h40, 16'h0FF0);
        @(negedge clk);
        rd(8'h00, v); chk("R10 sampled low pins", v, 16'h5055);
        pin_in = 16'hABCD;
        repeat (2) @(negedge clk);
        rd(8'h00, v); chk("R10 not before third clock", v, 16'h5055);
        rd(8'h00, v); chk("R10 sampled at third clock", v, 16'h5B55);
        chk("R11 outputs ignore pins", pin_out, 16'h0055);
        wr(8'h00, 16'hFFFF);
        rd(8'h00, v); chk("R10 write cannot change sampled", v, 16'hFBFF);
        pin_in = 16'h0000;
        repeat (4) @(negedge clk);
        exp_d = (16'hFBFF & ~16'h0F00);
        rd(8'h00, v); chk("R11 unsampled bits hold", v, exp_d);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // expected mask A after the sweep for group 1, last pattern p = 3
    function automatic logic [15:0] u_exp_a();
        logic [15:0] r;
        r = 16'h3C5A + 16'(3 * 16'h0F1F);
        r = r & ~(16'h00FF << 6);
        r = r | (16'h8001 | 16'(3 * 16'h0110));
        r = r ^ (16'hFFFF >> 3);
        return r;
    endfunction

endmodule